// File: doc/BRIEF.md
# Parallel PRBS Pattern Generator

This block is the pattern source of a link self-test path. Once per clock it produces a 10-bit word of pseudo-random data from one of four runtime-selectable polynomials. A single 9-bit control word drives it: an enable, a word-width code, a polynomial mode, a 3-bit decoupling threshold and a loopback select. The shift register steps ten times per clock through an unrolled next-state function, so each output word holds ten consecutive sequence bits. Bit 0 of the word is the earliest of those bits.

Software normally sets up the control word with the enable low and raises the enable after the downstream analyzer has left reset. Whenever generation becomes active, and whenever the polynomial changes while generation is active, the register is reseeded to all ones. The stream therefore always starts from a known point. The loopback select is passed on, registered, to steer the generated words into the lane checkers. The threshold field is carried in the control word and does not alter the pattern.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While reset is asserted and immediately after it, `patWord` is 0 and `loopSel` is 0.
- R2: When control bit 0 (enable) is low at a clock edge, `patWord` is 0 after that edge.
- R3: Control bits [4:3] select the polynomial: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. For a polynomial x^N+x^T+1, each step forms a new bit as the XOR of stages N and T and shifts it in at stage 1. One clock makes ten steps. Word bit k is the bit made by step k, with step 0 first.
- R4: Generation is active when bit 0 is 1 and bits [2:1] equal 3. On the first active edge after an inactive one, the register restarts from all ones, so the first word is the first ten bits that follow the all-ones seed.
- R5: A change of bits [4:3] while generation stays active reseeds to all ones at that edge and produces the first word of the new polynomial.
- R6: With the enable high and bits [2:1] not equal to 3, `patWord` is 0. Setting bits [2:1] back to 3 counts as becoming active under R4.
- R7: `loopSel` equals control bit 8 as sampled at the previous clock edge, whatever the enable state.
- R8: The threshold field in bits [7:5] has no effect on `patWord`, including when it changes every clock.
- R9: While active, the register never holds all zeros in its used stages. A stream on the 7-stage polynomial repeats every 127 clocks.
- R10: `patWord` is registered: the word after edge n reflects the control word sampled at edge n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWord | input | 9 | Control: [8] loopback, [7:5] threshold, [4:3] mode, [2:1] width code, [0] enable |
| patWord | output | 10 | Generated pattern word |
| loopSel | output | 1 | Registered loopback select |

## Verification
A polynomial change can land in the same clock as a loopback toggle and a threshold change. An enable rise can likewise land in the same cycle as a new mode. The bench provokes both by writing a control word that alters several fields at once. A scoreboard built on an independent bit-serial model then checks that the word after that edge is the fresh-seed word of the new polynomial. It also checks that `loopSel` follows bit 8 from the same edge. A second case stops and restarts generation through the width code instead of the enable, and the scoreboard confirms that the reseed also happens on that path.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  localparam int STATE_W   = 31;
  localparam int MODE_CNT  = 4;
  localparam logic [1:0] WORD10_CODE = 2'd3;

  typedef enum logic [1:0] {
    PAT_P11 = 2'd0,
    PAT_P15 = 2'd1,
    PAT_P7  = 2'd2,
    PAT_P31 = 2'd3
  } patMode_e;

  typedef struct packed {
    logic       loopBack;
    logic [2:0] decoupThr;
    patMode_e   mode;
    logic [1:0] wordSel;
    logic       enable;
  } genCfg_t;

  typedef struct packed {
    logic clear;
    logic reseed;
    logic advance;
  } genStrobe_t;

  function automatic int polyLen(input int m);
    case (m)
      0:       return 11;
      1:       return 15;
      2:       return 7;
      default: return 31;
    endcase
  endfunction

  function automatic int polyTap(input int m);
    case (m)
      0:       return 9;
      1:       return 14;
      2:       return 6;
      default: return 28;
    endcase
  endfunction

  function automatic logic [STATE_W-1:0] polyMask(input int m);
    return ~({STATE_W{1'b1}} << polyLen(m));
  endfunction

endpackage

// File: rtl/prbs_gen_ctrl.sv
module prbs_gen_ctrl
  import prbs_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  genCfg_t    cfg,
  output genStrobe_t strobe,
  output patMode_e   modeSel,
  output logic       loopOut
);

  logic     activeNow;
  logic     activeQ;
  patMode_e modeQ;

  assign activeNow = cfg.enable && (cfg.wordSel == WORD10_CODE);

  always_comb begin
    strobe.advance = activeNow;
    strobe.clear   = !activeNow;
    strobe.reseed  = activeNow && (!activeQ || (cfg.mode != modeQ));
  end

  assign modeSel = cfg.mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      modeQ   <= PAT_P11;
      loopOut <= 1'b0;
    end else begin
      activeQ <= activeNow;
      modeQ   <= cfg.mode;
      loopOut <= cfg.loopBack;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.clear, strobe.advance})) else $error("clear and advance together"); // R2

  AST_RESEED_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !activeQ) |-> strobe.reseed) else $error("no reseed on start"); // R4

  AST_MODE_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && activeQ && (cfg.mode != modeQ)) |-> strobe.reseed) else $error("no reseed on mode change"); // R5

endmodule

// File: rtl/prbs_gen_dp.sv
module prbs_gen_dp
  import prbs_gen_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  genStrobe_t        strobe,
  input  patMode_e          modeSel,
  output logic [WORD_W-1:0] word
);

  localparam logic [STATE_W-1:0] SEED = {STATE_W{1'b1}};

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] baseState;
  logic [STATE_W-1:0] nextSel;
  logic [WORD_W-1:0]  bitsSel;
  patMode_e           modeQ;

  assign baseState = strobe.reseed ? SEED : stateQ;

  for (genvar m = 0; m < MODE_CNT; m++) begin : stepG
    localparam int LEN = polyLen(m);
    localparam int TAP = polyTap(m);
    localparam logic [STATE_W-1:0] MASK = polyMask(m);

    logic [STATE_W-1:0] nxt;
    logic [WORD_W-1:0]  bits;

    always_comb begin
      logic [STATE_W-1:0] s;
      logic nb;
      s    = baseState & MASK;
      bits = '0;
      for (int k = 0; k < WORD_W; k++) begin
        nb      = s[LEN-1] ^ s[TAP-1];
        bits[k] = nb;
        s       = {s[STATE_W-2:0], nb} & MASK;
      end
      nxt = s;
    end
  end

  always_comb begin
    case (modeSel)
      PAT_P11: begin nextSel = stepG[0].nxt; bitsSel = stepG[0].bits; end
      PAT_P15: begin nextSel = stepG[1].nxt; bitsSel = stepG[1].bits; end
      PAT_P7:  begin nextSel = stepG[2].nxt; bitsSel = stepG[2].bits; end
      default: begin nextSel = stepG[3].nxt; bitsSel = stepG[3].bits; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= SEED;
      word   <= '0;
      modeQ  <= PAT_P11;
    end else if (strobe.clear) begin
      stateQ <= SEED;
      word   <= '0;
      modeQ  <= modeSel;
    end else if (strobe.advance) begin
      stateQ <= nextSel;
      word   <= bitsSel;
      modeQ  <= modeSel;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (word == '0)) else $error("word not zero while idle"); // R2

  AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> ((stateQ & polyMask(int'(modeQ))) != '0)) else $error("register reached zero"); // R9

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        cfgWord,
  output logic [WORD_W-1:0] patWord,
  output logic              loopSel
);

  genCfg_t    cfgS;
  genStrobe_t strobe;
  patMode_e   modeSel;

  assign cfgS = genCfg_t'(cfgWord);

  prbs_gen_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfgS),
    .strobe  (strobe),
    .modeSel (modeSel),
    .loopOut (loopSel)
  );

  prbs_gen_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .modeSel (modeSel),
    .word    (patWord)
  );

  AST_WIDTH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWord[2:1] != WORD10_CODE) |=> (patWord == '0)) else $error("output with bad width code"); // R6

  AST_LOOP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (loopSel == $past(cfgWord[8]))) else $error("loopSel lag wrong"); // R7

endmodule

// File: tb/sim_prbs_pattern_gen.sv
module sim_prbs_pattern_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cfgWord = '0;
  logic [9:0] patWord;
  logic       loopSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prbs_pattern_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgWord (cfgWord),
    .patWord (patWord),
    .loopSel (loopSel)
  );

  logic [10:0] expQ[$];
  string       tagQ[$];
  logic [9:0]  capArr[400];
  int          capN = 0;

  logic [30:0] mS = '1;
  logic        mPrevActive = 1'b0;
  logic [1:0]  mPrevMode = 2'd0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWord(input logic [8:0] c, output logic [9:0] w);
    logic act;
    int n, t;
    logic nb;
    act = c[0] && (c[2:1] == 2'b11);
    case (c[4:3])
      2'd0: begin n = 11; t = 9; end
      2'd1: begin n = 15; t = 14; end
      2'd2: begin n = 7; t = 6; end
      default: begin n = 31; t = 28; end
    endcase
    w = '0;
    if (!act) begin
      mS = '1;
    end else begin
      if (!mPrevActive || (c[4:3] != mPrevMode)) mS = '1;
      for (int k = 0; k < 10; k++) begin
        nb = mS[n-1] ^ mS[t-1];
        w[k] = nb;
        mS = {mS[29:0], nb};
      end
    end
    mPrevActive = act;
    mPrevMode = c[4:3];
  endtask

  task automatic drive(input logic [8:0] c, input string tag);
    logic [9:0] w;
    @(negedge clk);
    cfgWord = c;
    modelWord(c, w);
    expQ.push_back({c[8], w});
    tagQ.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (expQ.size() > 0) begin
        logic [10:0] e;
        string tg;
        e = expQ.pop_front();
        tg = tagQ.pop_front();
        check({tg, " word"}, {22'd0, patWord}, {22'd0, e[9:0]});
        check({tg, " loopSel"}, {31'd0, loopSel}, {31'd0, e[10]});
        if (tg == "R9" && capN < 400) begin
          capArr[capN] = patWord;
          capN++;
        end
      end
    end
  end

  function automatic logic [8:0] mk(input logic lb, input logic [2:0] thr,
                                    input logic [1:0] md, input logic [1:0] ws, input logic en);
    return {lb, thr, md, ws, en};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", {22'd0, patWord}, 32'd0);
    check("R1 reset loopSel", {31'd0, loopSel}, 32'd0);
    cfgWord = mk(1'b1, 3'd3, 2'd2, 2'd3, 1'b1);
    @(negedge clk);
    check("R1 word held in reset", {22'd0, patWord}, 32'd0);
    @(negedge clk);
    cfgWord = '0;
    rst_n = 1'b1;

    // R2 idle with enable low
    for (int i = 0; i < 5; i++) drive(mk(1'b0, 3'd3, 2'd2, 2'd3, 1'b0), "R2");
    // R4 start on the 7-stage polynomial, then R3 and R10 stream
    drive(mk(1'b0, 3'd3, 2'd2, 2'd3, 1'b1), "R4");
    for (int i = 0; i < 20; i++) drive(mk(1'b0, 3'd3, 2'd2, 2'd3, 1'b1), "R3");
    // R9 period capture
    for (int i = 0; i < 300; i++) drive(mk(1'b0, 3'd3, 2'd2, 2'd3, 1'b1), "R9");
    // R7 loopback toggling while active and idle
    for (int i = 0; i < 10; i++) drive(mk(i[0], 3'd3, 2'd2, 2'd3, 1'b1), "R7");
    for (int i = 0; i < 6; i++) drive(mk(~i[0], 3'd3, 2'd2, 2'd3, 1'b0), "R7");
    drive(mk(1'b0, 3'd3, 2'd2, 2'd3, 1'b1), "R4");
    // R8 threshold changes every clock
    for (int i = 0; i < 30; i++) drive(mk(1'b0, 3'(i), 2'd2, 2'd3, 1'b1), "R8");
    // R5 mode changes while active
    for (int i = 0; i < 40; i++) drive(mk(1'b0, 3'd3, 2'd0, 2'd3, 1'b1), "R5");
    for (int i = 0; i < 40; i++) drive(mk(1'b0, 3'd3, 2'd1, 2'd3, 1'b1), "R5");
    for (int i = 0; i < 60; i++) drive(mk(1'b0, 3'd3, 2'd3, 2'd3, 1'b1), "R5");
    // R6 width code gating and restart
    for (int i = 0; i < 4; i++) drive(mk(1'b0, 3'd3, 2'd3, 2'(i), 1'b1), "R6");
    for (int i = 0; i < 10; i++) drive(mk(1'b0, 3'd3, 2'd3, 2'd3, 1'b1), "R6");
    // R2 stop, then R4 restart on another polynomial
    for (int i = 0; i < 3; i++) drive(mk(1'b0, 3'd3, 2'd3, 2'd3, 1'b0), "R2");
    for (int i = 0; i < 10; i++) drive(mk(1'b0, 3'd3, 2'd1, 2'd3, 1'b1), "R4");
    // R5 mode change, loopback toggle and threshold change in one cycle
    drive(mk(1'b1, 3'd6, 2'd2, 2'd3, 1'b1), "R5");
    for (int i = 0; i < 8; i++) drive(mk(1'b1, 3'd6, 2'd2, 2'd3, 1'b1), "R5");
    drive(mk(1'b0, 3'd1, 2'd0, 2'd3, 1'b1), "R5");
    for (int i = 0; i < 8; i++) drive(mk(1'b0, 3'd1, 2'd0, 2'd3, 1'b1), "R5");
    repeat (4) @(negedge clk);
    // R9 the 7-stage stream repeats every 127 clocks
    for (int k = 0; k + 127 < capN; k += 7)
      check("R9 period", {22'd0, capArr[k + 127]}, {22'd0, capArr[k]});
    check("R9 captured", 32'(capN), 32'd300);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule